// File: doc/BRIEF.md
# CAN Operating-Mode and Bus-Off Recovery Controller

This block sets the operating mode of a CAN protocol engine. It holds the initialization control bit and the configuration-change-enable bit, and it decides when writes to protected configuration registers may go through. The engine enters initialization mode after reset, when software asks for it, or when the error logic reports bus-off. While initialization is active the transmit side is held recessive and the engine takes no part in traffic.

When software clears the initialization bit after an ordinary init, the block watches the sampled receive bit on each bit-time strobe. It releases normal operation once it has seen one run of consecutive recessive bits, which marks bus idle. After a bus-off the same run must be seen many times over before normal operation returns. Toggling the initialization bit part way through does not shorten that count. When recovery ends, the block sends a one-cycle clear to the error counters and drops the bus-off status.

Bit timing, framing and the error counters themselves belong to neighbouring blocks. This block only consumes the strobe and the sampled bit, and it only issues the clear pulse.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the initialization bit is 1, the change-enable bit is 0, the mode is INIT (code 0), the TX hold output is 1, and the bus-off status, bus-off interrupt, access-error and counter-clear outputs are all 0.
- R2: The TX hold output is 1 whenever the initialization bit is 1 or the mode is anything other than NORMAL (code 2). It is 0 in NORMAL with the initialization bit clear.
- R3: A control write changes the change-enable bit only while the initialization bit is already 1. A write that clears the initialization bit also clears the change-enable bit. A write that sets the initialization bit from 0 leaves the change-enable bit at 0.
- R4: The protected-write enable output equals the request ANDed with both the initialization bit and the change-enable bit, in the same cycle.
- R5: A protected-write request made while that enable is low is not passed on. It sets a sticky access-error flag on the next edge. The access-error clear input resets the flag, and a new error in the same cycle wins over the clear.
- R6: One cycle after software clears the initialization bit with no bus-off pending, the mode becomes WAIT_IDLE (code 1). The mode becomes NORMAL on the edge that takes the IDLE_BITS-th (11) consecutive recessive strobed bit. A dominant strobed bit restarts the run from zero.
- R7: A bus-off trigger sets the initialization bit, the bus-off status and the bus-off interrupt on the next edge, and forces the mode to INIT. The change-enable bit is left as it was. The interrupt clears only through its write-1 clear input.
- R8: With bus-off status set, clearing the initialization bit leads to mode BUSOFF_RECOVERY (code 3). NORMAL is reached only after RECOVERY_SEQS (129) complete runs of IDLE_BITS recessive bits. A dominant bit discards only the run in progress.
- R9: Setting and then clearing the initialization bit during recovery keeps the runs already completed. The total needed is still RECOVERY_SEQS, neither fewer nor more.
- R10: On the edge that completes recovery, the mode becomes NORMAL, the bus-off status clears, and the counter-clear output is 1 for exactly one cycle.
- R11: Software setting the initialization bit from WAIT_IDLE or NORMAL brings the mode back to INIT. It raises no counter-clear pulse and leaves the bus-off status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a sampled bit |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_init_wd | input | 1 | Write value for the initialization bit |
| ctl_cce_wd | input | 1 | Write value for the change-enable bit |
| prot_wr_req | input | 1 | Request to write a protected configuration register |
| bo_irq_clr | input | 1 | Write-1 clear for the bus-off interrupt |
| acc_err_clr | input | 1 | Write-1 clear for the access-error flag |
| busoff_trig | input | 1 | Bus-off event from the error logic |
| mode_o | output | 2 | Mode code: 0 INIT, 1 WAIT_IDLE, 2 NORMAL, 3 BUSOFF_RECOVERY |
| init_o | output | 1 | Initialization bit |
| cce_o | output | 1 | Change-enable bit |
| tx_hold_o | output | 1 | Forces the TX line recessive |
| cfg_wr_en_o | output | 1 | Protected-write enable |
| err_cnt_clr_o | output | 1 | One-cycle error-counter clear |
| bo_status_o | output | 1 | Bus-off status |
| bo_irq_o | output | 1 | Bus-off interrupt flag |
| acc_err_o | output | 1 | Sticky access-error flag |

## Verification
The assertions assume the bus-off trigger is not raised in the cycle right after a recovery completes, so that the counter-clear pulse always appears in NORMAL. They also assume the inputs are free of X once reset is released. The bench drives every input on the falling edge and raises the bus-off trigger only from NORMAL or INIT, never during a completion edge. Bit strobes come from one task that presents exactly one strobed bit per cycle. This keeps the run and sequence counts the bench expects equal to the ones the design sees.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [1:0] {
      MODE_INIT      = 2'd0,
      MODE_WAIT_IDLE = 2'd1,
      MODE_NORMAL    = 2'd2,
      MODE_BUSOFF_RC = 2'd3
   } mode_t;

   function automatic logic mode_counts(input mode_t m);
      return (m == MODE_WAIT_IDLE) || (m == MODE_BUSOFF_RC);
   endfunction

endpackage

// File: rtl/can_mode_ctlreg.sv
module can_mode_ctlreg (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_init_wd,
   input  logic ctl_cce_wd,
   input  logic busoff_trig,
   input  logic rec_done,
   input  logic prot_wr_req,
   input  logic bo_irq_clr,
   input  logic acc_err_clr,
   output logic init_q,
   output logic cce_q,
   output logic bo_status_q,
   output logic bo_irq_q,
   output logic acc_err_q,
   output logic cfg_wr_en
);

   logic init_d, cce_d, window_open;

   assign window_open = init_q & cce_q;
   assign cfg_wr_en   = prot_wr_req & window_open;

   always_comb begin
      init_d = init_q;
      cce_d  = cce_q;
      if (busoff_trig) begin
         init_d = 1'b1;
      end else if (ctl_wr) begin
         init_d = ctl_init_wd;
         if (init_q) begin
            cce_d = ctl_init_wd ? ctl_cce_wd : 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q      <= 1'b1;
         cce_q       <= 1'b0;
         bo_status_q <= 1'b0;
         bo_irq_q    <= 1'b0;
         acc_err_q   <= 1'b0;
      end else begin
         init_q <= init_d;
         cce_q  <= cce_d;
         if (busoff_trig)     bo_status_q <= 1'b1;
         else if (rec_done)   bo_status_q <= 1'b0;
         if (busoff_trig)     bo_irq_q <= 1'b1;
         else if (bo_irq_clr) bo_irq_q <= 1'b0;
         if (prot_wr_req && !window_open) acc_err_q <= 1'b1;
         else if (acc_err_clr)            acc_err_q <= 1'b0;
      end
   end

endmodule

// File: rtl/can_mode_idle_det.sv
module can_mode_idle_det #(
   parameter int IDLE_BITS     = 11,
   parameter int RECOVERY_SEQS = 129
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   input  logic seq_en,
   input  logic seq_clr,
   input  logic bit_tick,
   input  logic rx_bit,
   output logic run_done,
   output logic seq_done
);

   localparam int RW = $clog2(IDLE_BITS + 1);
   localparam int SW = $clog2(RECOVERY_SEQS + 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_BITS - 1);
   localparam logic [SW-1:0] SEQ_LAST = SW'(RECOVERY_SEQS - 1);

   logic [RW-1:0] run_q;
   logic [SW-1:0] seq_q;

   assign run_done = count_en & bit_tick & rx_bit & (run_q == RUN_LAST);
   assign seq_done = seq_en & run_done & (seq_q == SEQ_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!count_en) begin
         run_q <= '0;
      end else if (bit_tick) begin
         if (!rx_bit || run_done) run_q <= '0;
         else                     run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
      end else if (seq_clr || seq_done) begin
         seq_q <= '0;
      end else if (seq_en && run_done) begin
         seq_q <= seq_q + 1'b1;
      end
   end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  init_q,
   input  logic  busoff_trig,
   input  logic  bo_status_q,
   input  logic  run_done,
   input  logic  seq_done,
   output mode_t mode_q,
   output logic  err_clr_q,
   output logic  rec_done,
   output logic  count_en,
   output logic  seq_en
);

   mode_t mode_d;
   logic  hold;

   assign hold     = init_q | busoff_trig;
   assign count_en = mode_counts(mode_q) & ~init_q;
   assign seq_en   = (mode_q == MODE_BUSOFF_RC) & ~init_q;
   assign rec_done = seq_en & seq_done & ~busoff_trig;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_INIT:      if (!hold) mode_d = bo_status_q ? MODE_BUSOFF_RC : MODE_WAIT_IDLE;
         MODE_WAIT_IDLE: if (hold) mode_d = MODE_INIT;
                         else if (run_done) mode_d = MODE_NORMAL;
         MODE_NORMAL:    if (hold) mode_d = MODE_INIT;
         MODE_BUSOFF_RC: if (hold) mode_d = MODE_INIT;
                         else if (rec_done) mode_d = MODE_NORMAL;
         default:        mode_d = MODE_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_INIT;
         err_clr_q <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         err_clr_q <= rec_done;
      end
   end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int IDLE_BITS        = 11,
   parameter int RECOVERY_SEQS    = 129,
   parameter bit TX_HOLD_ON_INIT_ONLY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_tick,
   input  logic       rx_bit,
   input  logic       ctl_wr,
   input  logic       ctl_init_wd,
   input  logic       ctl_cce_wd,
   input  logic       prot_wr_req,
   input  logic       bo_irq_clr,
   input  logic       acc_err_clr,
   input  logic       busoff_trig,
   output logic [1:0] mode_o,
   output logic       init_o,
   output logic       cce_o,
   output logic       tx_hold_o,
   output logic       cfg_wr_en_o,
   output logic       err_cnt_clr_o,
   output logic       bo_status_o,
   output logic       bo_irq_o,
   output logic       acc_err_o
);

   generate
      if (IDLE_BITS < 2) begin : g_bad_idle
         $error("IDLE_BITS must be at least 2");
      end
      if (RECOVERY_SEQS < 1) begin : g_bad_seqs
         $error("RECOVERY_SEQS must be at least 1");
      end
   endgenerate

   logic  init_q, cce_q, bo_status_q, rec_done, count_en, seq_en;
   logic  run_done, seq_done, err_clr_q;
   mode_t mode_q;

   can_mode_ctlreg u_ctlreg (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_init_wd (ctl_init_wd),
      .ctl_cce_wd  (ctl_cce_wd),
      .busoff_trig (busoff_trig),
      .rec_done    (rec_done),
      .prot_wr_req (prot_wr_req),
      .bo_irq_clr  (bo_irq_clr),
      .acc_err_clr (acc_err_clr),
      .init_q      (init_q),
      .cce_q       (cce_q),
      .bo_status_q (bo_status_q),
      .bo_irq_q    (bo_irq_o),
      .acc_err_q   (acc_err_o),
      .cfg_wr_en   (cfg_wr_en_o)
   );

   can_mode_idle_det #(
      .IDLE_BITS     (IDLE_BITS),
      .RECOVERY_SEQS (RECOVERY_SEQS)
   ) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (count_en),
      .seq_en   (seq_en),
      .seq_clr  (busoff_trig),
      .bit_tick (bit_tick),
      .rx_bit   (rx_bit),
      .run_done (run_done),
      .seq_done (seq_done)
   );

   can_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_q      (init_q),
      .busoff_trig (busoff_trig),
      .bo_status_q (bo_status_q),
      .run_done    (run_done),
      .seq_done    (seq_done),
      .mode_q      (mode_q),
      .err_clr_q   (err_clr_q),
      .rec_done    (rec_done),
      .count_en    (count_en),
      .seq_en      (seq_en)
   );

   generate
      if (TX_HOLD_ON_INIT_ONLY) begin : g_tx_init
         assign tx_hold_o = init_q;
      end else begin : g_tx_mode
         assign tx_hold_o = init_q | (mode_q != MODE_NORMAL);
      end
   endgenerate

   assign mode_o        = mode_q;
   assign init_o        = init_q;
   assign cce_o         = cce_q;
   assign bo_status_o   = bo_status_q;
   assign err_cnt_clr_o = err_clr_q;

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       prot_wr_req,
   input logic       busoff_trig,
   input logic [1:0] mode_o,
   input logic       init_o,
   input logic       cce_o,
   input logic       tx_hold_o,
   input logic       cfg_wr_en_o,
   input logic       err_cnt_clr_o,
   input logic       bo_status_o,
   input logic       bo_irq_o,
   input logic       acc_err_o
);

   assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_o |-> tx_hold_o);

   assert_cce_needs_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !init_o |-> !cce_o);

   assert_wr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en_o |-> (init_o && cce_o));

   assert_acc_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_req && !cfg_wr_en_o) |=> acc_err_o);

   assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_trig |=> (init_o && bo_irq_o && bo_status_o));

   assert_clr_in_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_clr_o |-> (mode_o == 2'd2 && !bo_status_o && $past(mode_o) == 2'd3));

   assert_clr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_clr_o |=> !err_cnt_clr_o);

endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .prot_wr_req   (prot_wr_req),
   .busoff_trig   (busoff_trig),
   .mode_o        (mode_o),
   .init_o        (init_o),
   .cce_o         (cce_o),
   .tx_hold_o     (tx_hold_o),
   .cfg_wr_en_o   (cfg_wr_en_o),
   .err_cnt_clr_o (err_cnt_clr_o),
   .bo_status_o   (bo_status_o),
   .bo_irq_o      (bo_irq_o),
   .acc_err_o     (acc_err_o)
);

// File: tb/can_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_mode_ctrl_bench;

   localparam int IDLE = 11;
   localparam int SEQS = 129;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 0, rx_bit = 1, ctl_wr = 0, ctl_init_wd = 0, ctl_cce_wd = 0;
   logic prot_wr_req = 0, bo_irq_clr = 0, acc_err_clr = 0, busoff_trig = 0;
   logic [1:0] mode_o;
   logic init_o, cce_o, tx_hold_o, cfg_wr_en_o, err_cnt_clr_o, bo_status_o, bo_irq_o, acc_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   can_mode_ctrl u_can_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
      .ctl_wr(ctl_wr), .ctl_init_wd(ctl_init_wd), .ctl_cce_wd(ctl_cce_wd),
      .prot_wr_req(prot_wr_req), .bo_irq_clr(bo_irq_clr), .acc_err_clr(acc_err_clr),
      .busoff_trig(busoff_trig), .mode_o(mode_o), .init_o(init_o), .cce_o(cce_o),
      .tx_hold_o(tx_hold_o), .cfg_wr_en_o(cfg_wr_en_o), .err_cnt_clr_o(err_cnt_clr_o),
      .bo_status_o(bo_status_o), .bo_irq_o(bo_irq_o), .acc_err_o(acc_err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ctl(input logic i, input logic c);
      @(negedge clk);
      ctl_wr = 1; ctl_init_wd = i; ctl_cce_wd = c;
      @(negedge clk);
      ctl_wr = 0;
   endtask

   task automatic send_bits(input int n, input logic v);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         bit_tick = 1; rx_bit = v;
      end
      @(negedge clk);
      bit_tick = 0; rx_bit = 1;
   endtask

   task automatic pulse_busoff();
      @(negedge clk);
      busoff_trig = 1;
      @(negedge clk);
      busoff_trig = 0;
   endtask

   task automatic t_reset();
      chk("R1 init", init_o, 1);
      chk("R1 cce", cce_o, 0);
      chk("R1 mode", mode_o, 0);
      chk("R1 tx_hold", tx_hold_o, 1);
      chk("R1 flags", {bo_status_o, bo_irq_o, acc_err_o, err_cnt_clr_o}, 0);
   endtask

   task automatic t_config();
      @(negedge clk);
      prot_wr_req = 1; #1;
      chk("R4 en closed", cfg_wr_en_o, 0);
      @(negedge clk);
      prot_wr_req = 0;
      chk("R5 acc_err set", acc_err_o, 1);
      acc_err_clr = 1;
      @(negedge clk);
      acc_err_clr = 0;
      chk("R5 acc_err clear", acc_err_o, 0);
      ctl(1, 1);
      chk("R3 cce set in init", cce_o, 1);
      prot_wr_req = 1; #1;
      chk("R4 en open", cfg_wr_en_o, 1);
      @(negedge clk);
      prot_wr_req = 0;
      chk("R5 no acc_err", acc_err_o, 0);
      ctl(0, 1);
      chk("R3 cce cleared with init", cce_o, 0);
      ctl(1, 1);
      chk("R3 cce ignored on init set", cce_o, 0);
      ctl(1, 1);
      chk("R3 cce set second", cce_o, 1);
      ctl(1, 0);
   endtask

   task automatic t_wait_idle();
      ctl(0, 0);
      @(negedge clk);
      chk("R6 wait mode", mode_o, 1);
      chk("R2 hold in wait", tx_hold_o, 1);
      send_bits(6, 1);
      send_bits(1, 0);
      send_bits(IDLE - 1, 1);
      chk("R6 not yet normal", mode_o, 1);
      send_bits(1, 1);
      chk("R6 normal", mode_o, 2);
      chk("R2 tx released", tx_hold_o, 0);
   endtask

   task automatic t_sw_init();
      ctl(1, 0);
      chk("R2 hold with init", tx_hold_o, 1);
      @(negedge clk);
      chk("R11 back to init", mode_o, 0);
      chk("R11 no clear", err_cnt_clr_o, 0);
      chk("R11 bo unchanged", bo_status_o, 0);
      ctl(0, 0);
      @(negedge clk);
      ctl(1, 0);
      @(negedge clk);
      chk("R11 wait to init", mode_o, 0);
      ctl(0, 0);
      @(negedge clk);
      send_bits(IDLE, 1);
      chk("R6 normal again", mode_o, 2);
   endtask

   task automatic t_busoff();
      pulse_busoff();
      chk("R7 init set", init_o, 1);
      chk("R7 status", bo_status_o, 1);
      chk("R7 irq", bo_irq_o, 1);
      chk("R7 mode init", mode_o, 0);
      chk("R7 cce kept", cce_o, 0);
      repeat (3) @(negedge clk);
      chk("R7 irq sticky", bo_irq_o, 1);
      bo_irq_clr = 1;
      @(negedge clk);
      bo_irq_clr = 0;
      chk("R7 irq cleared", bo_irq_o, 0);
      ctl(0, 0);
      @(negedge clk);
      chk("R8 recovery mode", mode_o, 3);
      send_bits(50 * IDLE, 1);
      send_bits(7, 1);
      send_bits(1, 0);
      chk("R8 still recovering", mode_o, 3);
      ctl(1, 0);
      @(negedge clk);
      chk("R9 init during recovery", mode_o, 0);
      ctl(0, 0);
      @(negedge clk);
      chk("R9 resume recovery", mode_o, 3);
      send_bits((SEQS - 51) * IDLE, 1);
      send_bits(IDLE - 1, 1);
      chk("R9 not shortened", mode_o, 3);
      chk("R10 status held", bo_status_o, 1);
      chk("R10 no early clear", err_cnt_clr_o, 0);
      @(negedge clk);
      bit_tick = 1; rx_bit = 1;
      @(negedge clk);
      bit_tick = 0;
      chk("R10 normal", mode_o, 2);
      chk("R10 clear pulse", err_cnt_clr_o, 1);
      chk("R10 status cleared", bo_status_o, 0);
      @(negedge clk);
      chk("R10 pulse one cycle", err_cnt_clr_o, 0);
      chk("R2 tx after recovery", tx_hold_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_config();
      t_wait_idle();
      t_sw_init();
      t_busoff();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule